// File: doc/BRIEF.md
# SDRAM Open-Row Read Sequencer

This block sits between a host that asks for single read bursts and an SDRAM device. It turns each accepted request into the shortest legal command sequence for the device. It remembers, for every internal bank, whether a row is open and which row that is. There are three cases:

- **Hit.** The request targets the row already open in its bank. The block sends only a read.
- **Closed bank.** The bank has no open row. The block sends an activate, then the read.
- **Conflict.** A different row is open in the bank. The block first closes that bank with a single-bank precharge, then sends the activate and the read.

Gaps between commands are enforced by parameterised precharge-to-activate and activate-to-read delays. After the read, the block flags the returning data words, one per clock, once the CAS latency has elapsed. It takes no new request until the last word of the burst has gone by.

The host side is a level request with bank, row and column fields, answered by a one-cycle acknowledge. The memory side carries:

- an active-low `{ras, cas, we}` command;
- a bank select;
- a shared row/column address;
- a data-valid flag with a beat index and a last-beat marker.

Top module: `sdram_rd_sequencer`

## Requirements
- R1: After reset every bank is treated as closed, `sd_cmd` is NOP (3'b111), `req_ack` is low and `rd_valid` is low. The first request to any bank therefore begins with an activate and no precharge.
- R2: A request seen in the idle state is accepted at the next clock edge. In the following cycle `req_ack` is high for exactly that cycle. For a closed bank, that same cycle carries an activate (3'b011) with the row on `sd_addr` and the bank on `sd_bank`.
- R3: A request whose row equals the open row of its bank gets only a read command (3'b101), issued in the acknowledge cycle. No precharge and no activate are issued.
- R4: A request whose row differs from the open row of its bank gets a precharge (3'b010) in the acknowledge cycle, then an activate of the new row, then a read. The precharge drives `sd_addr` to zero, so bit `PRE_SEL_BIT` (bit 10) is low, which marks it as a single-bank precharge.
- R5: An activate follows its precharge by exactly `T_RP` cycles, and a read follows its activate by exactly `T_RCD` cycles.
- R6: A read carries the column zero-extended in the low bits of `sd_addr`, with bit `PRE_SEL_BIT` low.
- R7: `rd_valid` is high for exactly `BURST_LEN` consecutive cycles, starting `CAS_LAT` cycles after the read command. `rd_beat` counts 0 upward over those cycles, and `rd_last` is high only on the final one.
- R8: While a request is in progress, a held request is not acknowledged. The next acknowledge comes at the earliest two cycles after the `rd_last` cycle.
- R9: The open-row state of each bank is independent. Opening a row in one bank neither closes nor changes the row held open in another bank.
- R10: In every cycle without a command, `sd_cmd` is NOP and `sd_bank` and `sd_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host read request, held until acknowledged |
| req_bank | input | BANK_W (2) | Internal bank of the request |
| req_row | input | ROW_W (12) | Row of the request |
| req_col | input | COL_W (9) | Starting column of the request |
| req_ack | output | 1 | One-cycle pulse: request taken |
| sd_cmd | output | 3 | Active-low {ras, cas, we} command |
| sd_bank | output | BANK_W (2) | Bank select for the command |
| sd_addr | output | ROW_W (12) | Row or column address; bit PRE_SEL_BIT selects precharge scope |
| rd_valid | output | 1 | A read data word is on the data bus this cycle |
| rd_beat | output | BEAT_W (2) | Index of the current data word in the burst |
| rd_last | output | 1 | Final data word of the burst |

## Verification
The in-line assertions watch command legality on every cycle:

- an activate only reaches a closed bank;
- a precharge only reaches an open bank;
- a read only reaches the open row of its bank;
- the precharge-to-activate and activate-to-read gaps are never short;
- data-valid cycles run back to back with a stepping beat index;
- no acknowledge overlaps a burst.

Only the bench's scenarios can show that the right sequence was chosen for a given history of rows and banks. They also show that the gaps are exact rather than merely long enough, that the data window starts on the right cycle, and that a request held through a burst is taken at the earliest legal moment.

// File: rtl/sdrd_pkg.sv
package sdrd_pkg;

  // Active-low {ras, cas, we} encodings
  typedef enum logic [2:0] {
    SD_NOP = 3'b111,
    SD_ACT = 3'b011,
    SD_RD  = 3'b101,
    SD_PRE = 3'b010
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ACC_HIT   = 2'd0,
    ACC_EMPTY = 2'd1,
    ACC_MISS  = 2'd2
  } acc_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_WAIT_RP,
    ST_ACT,
    ST_WAIT_RCD,
    ST_READ,
    ST_BURST
  } seq_state_e;

  // A command in cycle c followed by one T cycles later needs T-1 filler cycles;
  // the wait state is entered with T-2 and leaves when the counter reaches zero.
  function automatic int unsigned gap_load(input int unsigned t);
    return (t > 2) ? t - 2 : 0;
  endfunction

  // First and last cycle (counted from the read command) that carry data
  function automatic int unsigned first_beat_tick(input int unsigned cl);
    return cl;
  endfunction

  function automatic int unsigned last_beat_tick(input int unsigned cl, input int unsigned bl);
    return cl + bl - 1;
  endfunction

endpackage

// File: rtl/sdrd_bank_table.sv
module sdrd_bank_table
  import sdrd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] look_bank,
  input  logic [ROW_W-1:0]  look_row,
  output acc_kind_e         look_kind,
  input  logic              open_en,
  input  logic [BANK_W-1:0] open_bank,
  input  logic [ROW_W-1:0]  open_row,
  input  logic              close_en,
  input  logic [BANK_W-1:0] close_bank,
  input  logic              rd_en,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [ROW_W-1:0]  rd_row
);

  localparam int BANKS = 1 << BANK_W;

  logic [BANKS-1:0] open_q;
  logic [ROW_W-1:0] row_q [BANKS];

  for (genvar gi = 0; gi < BANKS; gi++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[gi] <= 1'b0;
        row_q[gi]  <= '0;
      end else if (open_en && open_bank == BANK_W'(gi)) begin
        open_q[gi] <= 1'b1;
        row_q[gi]  <= open_row;
      end else if (close_en && close_bank == BANK_W'(gi)) begin
        open_q[gi] <= 1'b0;
      end
    end
  end

  always_comb begin
    if (!open_q[look_bank])                look_kind = ACC_EMPTY;
    else if (row_q[look_bank] == look_row) look_kind = ACC_HIT;
    else                                   look_kind = ACC_MISS;
  end

  // Activate only into a closed bank, precharge only an open one
  AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    open_en |-> !open_q[open_bank]);                               // R4
  AST_PRE_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    close_en |-> open_q[close_bank]);                              // R4
  AST_READ_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (open_q[rd_bank] && row_q[rd_bank] == rd_row));      // R3
  AST_OTHER_BANK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (open_en && open_q[look_bank] && look_bank != open_bank) |=> open_q[$past(look_bank)]); // R9

endmodule

// File: rtl/sdrd_gap_timer.sv
module sdrd_gap_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  AST_TIMER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));       // R5

endmodule

// File: rtl/sdrd_burst_tracker.sv
module sdrd_burst_tracker
  import sdrd_pkg::*;
#(
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4,
  parameter int BEAT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  output logic              rd_valid,
  output logic [BEAT_W-1:0] rd_beat,
  output logic              rd_last
);

  localparam int TICK_W = $clog2(CAS_LAT + BURST_LEN + 1);
  localparam logic [TICK_W-1:0] FIRST = TICK_W'(first_beat_tick(CAS_LAT));
  localparam logic [TICK_W-1:0] LAST  = TICK_W'(last_beat_tick(CAS_LAT, BURST_LEN));

  logic              busy_q;
  logic [TICK_W-1:0] tick_q;
  logic [TICK_W-1:0] beat_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tick_q <= '0;
    end else if (rd_issue) begin
      busy_q <= 1'b1;
      tick_q <= TICK_W'(1);
    end else if (busy_q) begin
      if (tick_q == LAST) begin
        busy_q <= 1'b0;
        tick_q <= '0;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign beat_full = tick_q - FIRST;
  assign rd_valid  = busy_q && (tick_q >= FIRST) && (tick_q <= LAST);
  assign rd_last   = busy_q && (tick_q == LAST);
  assign rd_beat   = rd_valid ? BEAT_W'(beat_full) : '0;

  AST_BURST_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_last) |=> rd_valid);                          // R7
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_last) |=> (rd_beat == $past(rd_beat) + 1'b1));  // R7
  AST_NO_READ_MID_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |-> !busy_q);                                         // R8

endmodule

// File: rtl/sdram_rd_sequencer.sv
module sdram_rd_sequencer
  import sdrd_pkg::*;
#(
  parameter int BANK_W      = 2,
  parameter int ROW_W       = 12,
  parameter int COL_W       = 9,
  parameter int PRE_SEL_BIT = 10,  // must exceed COL_W-1
  parameter int T_RP        = 2,   // >= 1
  parameter int T_RCD       = 2,   // >= 1
  parameter int CAS_LAT     = 2,   // >= 1
  parameter int BURST_LEN   = 4,
  parameter int BEAT_W      = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_ack,
  output logic [2:0]        sd_cmd,
  output logic [BANK_W-1:0] sd_bank,
  output logic [ROW_W-1:0]  sd_addr,
  output logic              rd_valid,
  output logic [BEAT_W-1:0] rd_beat,
  output logic              rd_last
);

  localparam int TMAX  = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int TMR_W = (TMAX < 2) ? 1 : $clog2(TMAX + 1);
  localparam logic [TMR_W-1:0] RP_LOAD  = TMR_W'(gap_load(T_RP));
  localparam logic [TMR_W-1:0] RCD_LOAD = TMR_W'(gap_load(T_RCD));

  seq_state_e        st_q, st_d;
  logic [BANK_W-1:0] cur_bank_q;
  logic [ROW_W-1:0]  cur_row_q;
  logic [COL_W-1:0]  cur_col_q;
  logic              ack_q;

  // Named internal events
  acc_kind_e         look_kind;
  logic              accept;
  logic              open_en, close_en, rd_issue;
  logic              timer_load, timer_expired;
  logic [TMR_W-1:0]  timer_val;
  sd_cmd_e           cmd;

  assign accept = (st_q == ST_IDLE) && req_valid;

  sdrd_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_bank  (req_bank),
    .look_row   (req_row),
    .look_kind  (look_kind),
    .open_en    (open_en),
    .open_bank  (cur_bank_q),
    .open_row   (cur_row_q),
    .close_en   (close_en),
    .close_bank (cur_bank_q),
    .rd_en      (rd_issue),
    .rd_bank    (cur_bank_q),
    .rd_row     (cur_row_q)
  );

  sdrd_gap_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (timer_expired)
  );

  sdrd_burst_tracker #(.CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .BEAT_W(BEAT_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_issue (rd_issue),
    .rd_valid (rd_valid),
    .rd_beat  (rd_beat),
    .rd_last  (rd_last)
  );

  always_comb begin
    st_d       = st_q;
    timer_load = 1'b0;
    timer_val  = '0;
    open_en    = 1'b0;
    close_en   = 1'b0;
    rd_issue   = 1'b0;
    cmd        = SD_NOP;
    sd_bank    = '0;
    sd_addr    = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          unique case (look_kind)
            ACC_HIT:   st_d = ST_READ;
            ACC_EMPTY: st_d = ST_ACT;
            default:   st_d = ST_PRE;
          endcase
        end
      end
      ST_PRE: begin
        cmd      = SD_PRE;
        sd_bank  = cur_bank_q;
        close_en = 1'b1;
        if (T_RP <= 1) begin
          st_d = ST_ACT;
        end else begin
          st_d       = ST_WAIT_RP;
          timer_load = 1'b1;
          timer_val  = RP_LOAD;
        end
      end
      ST_WAIT_RP:  if (timer_expired) st_d = ST_ACT;
      ST_ACT: begin
        cmd     = SD_ACT;
        sd_bank = cur_bank_q;
        sd_addr = cur_row_q;
        open_en = 1'b1;
        if (T_RCD <= 1) begin
          st_d = ST_READ;
        end else begin
          st_d       = ST_WAIT_RCD;
          timer_load = 1'b1;
          timer_val  = RCD_LOAD;
        end
      end
      ST_WAIT_RCD: if (timer_expired) st_d = ST_READ;
      ST_READ: begin
        cmd      = SD_RD;
        sd_bank  = cur_bank_q;
        sd_addr  = ROW_W'(cur_col_q);
        rd_issue = 1'b1;
        st_d     = ST_BURST;
      end
      ST_BURST:    if (rd_last) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      ack_q      <= 1'b0;
      cur_bank_q <= '0;
      cur_row_q  <= '0;
      cur_col_q  <= '0;
    end else begin
      st_q  <= st_d;
      ack_q <= accept;
      if (accept) begin
        cur_bank_q <= req_bank;
        cur_row_q  <= req_row;
        cur_col_q  <= req_col;
      end
    end
  end

  assign req_ack = ack_q;
  assign sd_cmd  = cmd;

  // Gap monitors for the timing checks (saturating cycle counts since last command)
  logic [7:0] since_pre_q, since_act_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_pre_q <= 8'hff;
      since_act_q <= 8'hff;
    end else begin
      since_pre_q <= (sd_cmd == SD_PRE) ? 8'd1 : (since_pre_q == 8'hff ? 8'hff : since_pre_q + 8'd1);
      since_act_q <= (sd_cmd == SD_ACT) ? 8'd1 : (since_act_q == 8'hff ? 8'hff : since_act_q + 8'd1);
    end
  end

  AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == SD_ACT) |-> (since_pre_q >= 8'(T_RP)));             // R5
  AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == SD_RD) |-> (since_act_q >= 8'(T_RCD)));             // R5
  AST_PRE_SINGLE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == SD_PRE) |-> !sd_addr[PRE_SEL_BIT]);                 // R4
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);                                         // R2
  AST_ACK_NOT_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> !rd_valid);                                        // R8
  AST_ACK_FIRST_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (sd_cmd != SD_NOP));                               // R2
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == SD_NOP) |-> (sd_addr == '0 && sd_bank == '0));      // R10

endmodule

// File: tb/sim_sdram_rd_sequencer.sv
module sim_sdram_rd_sequencer;

  localparam int T_RP  = 3;
  localparam int T_RCD = 2;
  localparam int CL    = 3;
  localparam int BL    = 4;

  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101, C_PRE = 3'b010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [11:0] req_row = '0;
  logic [8:0]  req_col = '0;
  logic        req_ack;
  logic [2:0]  sd_cmd;
  logic [1:0]  sd_bank;
  logic [11:0] sd_addr;
  logic        rd_valid;
  logic [1:0]  rd_beat;
  logic        rd_last;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  sdram_rd_sequencer #(
    .T_RP(T_RP), .T_RCD(T_RCD), .CAS_LAT(CL), .BURST_LEN(BL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_ack(req_ack), .sd_cmd(sd_cmd),
    .sd_bank(sd_bank), .sd_addr(sd_addr), .rd_valid(rd_valid), .rd_beat(rd_beat),
    .rd_last(rd_last)
  );

  // Bench model of open rows
  bit          m_open [4];
  logic [11:0] m_row  [4];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int kind_of(input logic [1:0] b, input logic [11:0] r);
    if (!m_open[b]) return 1;      // closed bank
    if (m_row[b] == r) return 0;   // hit
    return 2;                      // conflict
  endfunction

  // Issue one request and check every cycle up to the last data word.
  // Called at a negedge while the design is idle. With keep set, the request
  // stays asserted so the next call sees it already pending.
  task automatic run_req(input logic [1:0] b, input logic [11:0] r, input logic [8:0] c,
                         input bit keep, input string first_tag);
    int kind = kind_of(b, r);
    int t_act = (kind == 2) ? T_RP : 0;
    int t_rd  = (kind == 0) ? 0 : t_act + T_RCD;
    int t_end = t_rd + CL + BL - 1;
    string ktag = (kind == 0) ? "R3" : (kind == 1) ? "R2" : "R4";
    req_valid = 1'b1; req_bank = b; req_row = r; req_col = c;
    @(negedge clk);
    for (int t = 0; t <= t_end; t++) begin
      logic [2:0]  e_cmd  = C_NOP;
      logic [11:0] e_addr = '0;
      logic [1:0]  e_bank = '0;
      bit          e_val  = (t >= t_rd + CL) && (t <= t_end);
      string       ctag;
      if (kind == 2 && t == 0)       e_cmd = C_PRE;
      else if (kind != 0 && t == t_act) begin e_cmd = C_ACT; e_addr = r; end
      else if (t == t_rd)            begin e_cmd = C_RD;  e_addr = {3'b000, c}; end
      if (e_cmd != C_NOP) e_bank = b;
      if (e_cmd == C_NOP)                    ctag = "R10";
      else if (t == 0)                       ctag = (first_tag != "") ? first_tag : ktag;
      else                                   ctag = "R5";
      chk(req_ack == (t == 0), (t == 0) ? "R2" : "R8", req_ack, (t == 0));
      chk(sd_cmd == e_cmd, ctag, sd_cmd, e_cmd);
      chk(sd_bank == e_bank, ctag, sd_bank, e_bank);
      chk(sd_addr == e_addr, (e_cmd == C_RD) ? "R6" : ctag, sd_addr, e_addr);
      chk(rd_valid == e_val, "R7", rd_valid, e_val);
      chk(rd_last == (t == t_end), "R7", rd_last, (t == t_end));
      if (e_val) chk(rd_beat == 2'(t - (t_rd + CL)), "R7", rd_beat, t - (t_rd + CL));
      if (t == 0 && !keep) req_valid = 1'b0;
      @(negedge clk);
    end
    // Cycle after the last word: idle, nothing acknowledged yet
    chk(req_ack == 1'b0, "R8", req_ack, 0);
    chk(sd_cmd == C_NOP, "R10", sd_cmd, C_NOP);
    if (kind != 0) begin m_open[b] = 1'b1; m_row[b] = r; end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sd_cmd == C_NOP, "R1", sd_cmd, C_NOP);
    chk(req_ack == 1'b0, "R1", req_ack, 0);
    chk(rd_valid == 1'b0, "R1", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sd_cmd == C_NOP, "R1", sd_cmd, C_NOP);

    // R1/R2: first use of a bank opens it directly
    run_req(2'd0, 12'h005, 9'h011, 1'b0, "R1");
    // R3: hit on the open row
    run_req(2'd0, 12'h005, 9'h1ff, 1'b0, "");
    // R4: row conflict
    run_req(2'd0, 12'h7a3, 9'h020, 1'b0, "");
    // R9: other banks leave bank 0 open on its row
    run_req(2'd1, 12'h007, 9'h003, 1'b0, "R9");
    run_req(2'd3, 12'hfff, 9'h100, 1'b0, "R9");
    run_req(2'd0, 12'h7a3, 9'h000, 1'b0, "R9");
    // R8: request held through a burst, then taken at the earliest cycle
    run_req(2'd1, 12'h007, 9'h055, 1'b1, "");
    run_req(2'd1, 12'h007, 9'h055, 1'b1, "R8");
    run_req(2'd1, 12'h008, 9'h056, 1'b0, "R8");

    // Random traffic over a small row set so hits, conflicts and opens mix
    for (int i = 0; i < 60; i++) begin
      logic [1:0]  rb = 2'($urandom_range(0, 3));
      logic [11:0] rr = 12'($urandom_range(0, 3)) << 9;
      logic [8:0]  rc = 9'($urandom);
      bit          rk = ($urandom_range(0, 3) == 0);
      run_req(rb, rr, rc, rk, "");
      if (rk) begin
        // Pending request is the same one again: it must now hit
        run_req(rb, rr, rc, 1'b0, "R8");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule